// File: doc/BRIEF.md
# Blowfish Key Schedule Sequencer

This block expands a secret key of one to fourteen 32-bit words into the complete Blowfish subkey set. That set has two parts: an array of eighteen 32-bit round keys and four substitution tables of 256 words each. Before a schedule runs, the host writes the fixed starting constants into every entry through an initialisation port, so no constant data is built into the block. The host then presents the key and pulses `start`.

The sequencer first mixes the key into the round-key array. It then runs its own single-block encryptor 521 times in a chain. The first run encrypts an all-zero block, and each later run encrypts the output of the run before it. Each output pair overwrites the next two entries: first the round keys, then the four tables in turn. Because every write changes the subkeys used by the following encryptions, the result depends on the exact order of the writes.

A combinational read port exposes any entry to the downstream data encryptor. `busy` frames the whole sequence, and `done` marks its end.

Top module: `bf_key_sched`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While idle, a write on the initialisation port stores `init_data` at `init_addr`, and the same address on `rd_addr` returns it. Addresses with bit 10 set select round key `addr[4:0]` (0..17); a higher index reads as zero and is not written. Addresses with bit 10 clear select table `addr[9:8]` (0..3), entry `addr[7:0]`.
- R3: On start, round key i (0..17) is XORed with key word j, where word j is `key_in[32*j +: 32]`. j starts at 0, steps once per round key, and wraps to 0 after word `key_len-1`. `key_len` is 1..14, and `key_in` must stay stable while busy.
- R4: Encryption follows the 16-round Feistel structure with round keys 0..15 and output whitening by keys 16 and 17. F(x) = ((T0[x[31:24]] + T1[x[23:16]]) XOR T2[x[15:8]]) + T3[x[7:0]], modulo 2^32. The zero block is encrypted first, and each later encryption takes the previous output as its input.
- R5: The first nine outputs replace round-key pairs (0,1), (2,3) … (16,17) in that order. The left half goes to the lower index and the right half to the higher. Each replacement takes effect before the next encryption starts.
- R6: The next 512 outputs replace entry pairs (0,1) … (254,255) of table 0, then table 1, then table 2, then table 3, using the same left/right rule.
- R7: `done` goes high exactly 8875 clock edges after the edge that accepts `start`, stays high for one cycle, and coincides with `busy` falling. `busy` stays high in every cycle between.
- R8: A `start` pulse while busy is ignored. The sequence neither restarts nor changes length.
- R9: Initialisation writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a schedule (accepted only when idle) |
| key_len | input | 4 | Number of valid key words, 1..14 |
| key_in | input | 448 | Key words, word j in bits 32*j+31..32*j |
| init_we | input | 1 | Initialisation write strobe |
| init_addr | input | 11 | Initialisation write address |
| init_data | input | 32 | Initialisation write data |
| rd_addr | input | 11 | Read address, same map as init_addr |
| rd_data | output | 32 | Entry at rd_addr |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle end-of-schedule pulse |

## Verification
The bench compares every one of the 1042 entries against an arithmetic model after schedules with one, five and fourteen key words. The single-word key catches a key pointer that fails to wrap. A swapped half or an off-by-one pair index corrupts the first round-key write, and the chained feedback then spreads that error through every later entry. A design that applied its updates late, or restarted on a second `start`, would either end with wrong contents or take other than 8875 edges. A design that honoured an initialisation write to round key 0 mid-run would leave that key, and all later entries, different from the model.

// File: rtl/bf_key_sched.sv
module bf_key_sched #(
  parameter int NROUNDS = 16,
  parameter int KEY_MAX = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [3:0]            key_len,
  input  logic [KEY_MAX*32-1:0] key_in,
  input  logic                  init_we,
  input  logic [10:0]           init_addr,
  input  logic [31:0]           init_data,
  input  logic [10:0]           rd_addr,
  output logic [31:0]           rd_data,
  output logic                  busy,
  output logic                  done
);
  localparam int PN    = NROUNDS + 2;
  localparam int SLOTS = PN / 2 + 512;
  localparam int PW    = $clog2(PN);
  localparam int RW    = $clog2(NROUNDS);
  localparam int SW    = $clog2(SLOTS);
  localparam logic [PW-1:0] PN_W   = PW'(PN);
  localparam logic [PW-1:0] PLAST  = PW'(PN - 1);
  localparam logic [RW-1:0] RLAST  = RW'(NROUNDS - 1);
  localparam logic [SW-1:0] PPAIRS = SW'(PN / 2);
  localparam logic [SW-1:0] SLAST  = SW'(SLOTS - 1);
  localparam logic [3:0]    KLAST  = 4'(KEY_MAX - 1);

  typedef enum logic [1:0] {S_IDLE, S_MIX, S_ENC, S_WB} st_t;

  st_t          st;
  logic [31:0]  pk [PN];
  logic [31:0]  sb [4][256];
  logic [31:0]  xl, xr;
  logic [PW-1:0] pi;
  logic [3:0]   kp;
  logic [RW-1:0] rnd;
  logic [SW-1:0] slot;

  logic [31:0] kword, fin, fo, ol, orr;
  logic [PW-1:0] pidx;
  logic [8:0]  tslot;
  logic [1:0]  tsel;
  logic [7:0]  tidx;

  assign kword = key_in[kp*32 +: 32];
  assign fin   = xl ^ pk[PW'(rnd)];
  assign fo    = ((sb[0][fin[31:24]] + sb[1][fin[23:16]]) ^ sb[2][fin[15:8]]) + sb[3][fin[7:0]];
  assign ol    = xr ^ pk[PN-1];
  assign orr   = xl ^ pk[PN-2];
  assign pidx  = PW'({slot, 1'b0});
  assign tslot = 9'(slot - PPAIRS);
  assign tsel  = tslot[8:7];
  assign tidx  = {tslot[6:0], 1'b0};

  assign busy = (st != S_IDLE);
  assign rd_data = rd_addr[10] ? ((rd_addr[PW-1:0] < PN_W) ? pk[rd_addr[PW-1:0]] : 32'h0)
                               : sb[rd_addr[9:8]][rd_addr[7:0]];

  always_ff @(posedge clk) begin
    if (st == S_IDLE && init_we) begin
      if (init_addr[10]) begin
        if (init_addr[PW-1:0] < PN_W) pk[init_addr[PW-1:0]] <= init_data;
      end else begin
        sb[init_addr[9:8]][init_addr[7:0]] <= init_data;
      end
    end
    if (st == S_MIX) pk[pi] <= pk[pi] ^ kword;
    if (st == S_WB) begin
      if (slot < PPAIRS) begin
        pk[pidx]            <= ol;
        pk[PW'(pidx + 1'b1)] <= orr;
      end else begin
        sb[tsel][tidx]         <= ol;
        sb[tsel][tidx | 8'd1]  <= orr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
      pi   <= '0;
      kp   <= '0;
      rnd  <= '0;
      slot <= '0;
      xl   <= '0;
      xr   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_MIX;
          pi <= '0;
          kp <= '0;
        end
        S_MIX: begin
          pi <= pi + 1'b1;
          kp <= (kp == key_len - 4'd1 || kp == KLAST) ? '0 : kp + 4'd1;
          if (pi == PLAST) begin
            st   <= S_ENC;
            rnd  <= '0;
            slot <= '0;
            xl   <= '0;
            xr   <= '0;
          end
        end
        S_ENC: begin
          xl  <= xr ^ fo;
          xr  <= fin;
          rnd <= rnd + 1'b1;
          if (rnd == RLAST) st <= S_WB;
        end
        default: begin
          xl  <= ol;
          xr  <= orr;
          rnd <= '0;
          if (slot == SLAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
            st   <= S_ENC;
          end
        end
      endcase
    end
  end
endmodule

module bf_key_sched_chk #(
  parameter int NROUNDS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        init_we,
  input logic [10:0] rd_addr,
  input logic [31:0] rd_data
);
  localparam int PN = NROUNDS + 2;
  localparam int TOTAL = PN + (PN / 2 + 512) * (NROUNDS + 1);
  logic [15:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 16'd1;
    else bcnt <= '0;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r7:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_fall_done_r7:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  p_accept_r7:     assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_length_r8:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (bcnt == 16'(TOTAL)));
  p_idle_hold_r2:  assert property (@(posedge clk) disable iff (!rst_n)
                     (!busy && !init_we && !start) |=> ($stable(rd_addr) |-> $stable(rd_data)));
endmodule

bind bf_key_sched bf_key_sched_chk #(.NROUNDS(NROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .init_we(init_we), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/bf_key_sched_test.sv
module bf_key_sched_test;
  localparam int EXP_LEN = 18 + 521 * 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] key_len = 4'd1;
  logic [447:0] key_in = '0;
  logic init_we = 1'b0;
  logic [10:0] init_addr = '0;
  logic [31:0] init_data = '0;
  logic [10:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic busy, done;

  int total = 0;
  int fails = 0;

  logic [31:0] mp [18];
  logic [31:0] ms [4][256];

  always #10 clk = ~clk;

  bf_key_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key_in(key_in),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cval(input int a, input int seed);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B9 ^ 32'(seed) * 32'h7F4A7C15;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [31:0] mf(input logic [31:0] x);
    return ((ms[0][x[31:24]] + ms[1][x[23:16]]) ^ ms[2][x[15:8]]) + ms[3][x[7:0]];
  endfunction

  task automatic menc(inout logic [31:0] l, inout logic [31:0] r);
    logic [31:0] t;
    for (int i = 0; i < 16; i++) begin
      l = l ^ mp[i];
      r = r ^ mf(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ mp[16];
    l = l ^ mp[17];
  endtask

  task automatic model_sched(input int kw);
    logic [31:0] l, r;
    int j;
    j = 0;
    for (int i = 0; i < 18; i++) begin
      mp[i] = mp[i] ^ key_in[32*j +: 32];
      j = (j + 1) % kw;
    end
    l = 0; r = 0;
    for (int s = 0; s < 9; s++) begin
      menc(l, r);
      mp[2*s] = l; mp[2*s+1] = r;
    end
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 256; i += 2) begin
        menc(l, r);
        ms[t][i] = l; ms[t][i+1] = r;
      end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    init_addr = a; init_data = d; init_we = 1'b1;
    @(posedge clk); @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic load_all(input int seed);
    for (int i = 0; i < 18; i++) begin
      mp[i] = cval(2000 + i, seed);
      wr(11'h400 | 11'(i), mp[i]);
    end
    for (int a = 0; a < 1024; a++) begin
      ms[a / 256][a % 256] = cval(a, seed);
      wr(11'(a), ms[a / 256][a % 256]);
    end
  endtask

  task automatic compare_all(input string pt, input string st);
    int bad;
    logic [31:0] fa, fe;
    bad = 0; fa = 0; fe = 0;
    for (int i = 0; i < 18; i++) begin
      rd_addr = 11'h400 | 11'(i); #1;
      if (rd_data !== mp[i]) begin
        if (bad == 0) begin fa = rd_data; fe = mp[i]; end
        bad++;
      end
    end
    check(bad == 0, pt, fa, fe);
    bad = 0;
    for (int a = 0; a < 1024; a++) begin
      rd_addr = 11'(a); #1;
      if (rd_data !== ms[a / 256][a % 256]) begin
        if (bad == 0) begin fa = rd_data; fe = ms[a / 256][a % 256]; end
        bad++;
      end
    end
    check(bad == 0, st, fa, fe);
  endtask

  task automatic run_sched(input int kw, input int restart_at, input int wr_at, output int n);
    bit busy_ok;
    key_len = 4'(kw);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    n = 0;
    busy_ok = 1'b1;
    while (n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      start = (n == restart_at);
      init_we = (n == wr_at);
      init_addr = 11'h400;
      init_data = 32'hA5A5_5A5A;
    end
    start = 1'b0; init_we = 1'b0;
    check(n == EXP_LEN, "R7 done latency", 32'(n), 32'(EXP_LEN));
    check(busy_ok, "R7 busy held", 32'(busy_ok), 32'd1);
    check(!busy, "R7 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    check(!done, "R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    #35;
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    load_all(1);
    for (int k = 0; k < 1042; k += 131) begin
      if (k < 18) begin rd_addr = 11'h400 | 11'(k); #1;
        check(rd_data === mp[k], "R2 round key readback", rd_data, mp[k]);
      end else begin rd_addr = 11'(k - 18); #1;
        check(rd_data === ms[(k-18)/256][(k-18)%256], "R2 table readback", rd_data, ms[(k-18)/256][(k-18)%256]);
      end
    end
    wr(11'h400 | 11'd20, 32'h1234_5678);
    rd_addr = 11'h400 | 11'd20; #1;
    check(rd_data === 32'h0, "R2 out-of-range key index", rd_data, 32'h0);
    rd_addr = 11'h400 | 11'd17; #1;
    check(rd_data === mp[17], "R2 key 17 untouched", rd_data, mp[17]);
    @(negedge clk);

    key_in = '0;
    key_in[31:0] = 32'hC0FF_EE11;
    model_sched(1);
    run_sched(1, -1, -1, n);
    compare_all("R3 R4 R5 one-word key round keys", "R6 one-word key tables");

    load_all(2);
    for (int j = 0; j < 14; j++) key_in[32*j +: 32] = cval(5000 + j, 7);
    model_sched(14);
    run_sched(14, 3000, -1, n);
    check(n == EXP_LEN, "R8 restart ignored length", 32'(n), 32'(EXP_LEN));
    compare_all("R3 R5 R8 fourteen-word key round keys", "R6 R8 fourteen-word key tables");

    load_all(3);
    for (int j = 0; j < 14; j++) key_in[32*j +: 32] = cval(9000 + j, 11);
    model_sched(5);
    run_sched(5, -1, 5000, n);
    rd_addr = 11'h400; #1;
    check(rd_data === mp[0], "R9 busy write ignored", rd_data, mp[0]);
    compare_all("R3 R5 R9 five-word key round keys", "R6 R9 five-word key tables");

    summary();
    $finish;
  end
endmodule